// File: doc/BRIEF.md
# Hashed page table walker

This block translates a 32-bit effective address through a segmented, hashed page table once a block-translation lookup has missed. The top bits of the address select one of sixteen segment registers. The selected register supplies a virtual segment identifier, a protection key and a no-execute flag, or it marks the segment as a direct-store segment. From the segment identifier and the page index the walker forms a hash. It scans the group of page-table entries that the hash selects, and if that group gives nothing usable it scans a second group at the complemented hash.

Entries are fetched one 32-bit word at a time over a valid/ready read port. When an entry matches, the walker checks the access against the entry's protection bits. It sets the referenced and changed bits where the access calls for it and writes the entry's second word back over a valid/ready write port, but only when a bit actually changed. It then reports a status, the real address and the read/write/execute permissions, together with a one-cycle done pulse. Software loads the segment registers through a small write port, and the table base and group mask are plain inputs.

Top module: `hashed_pt_walker`

## Requirements
- R1: The protection key is 1 when segment register bit 29 is set and the request is unprivileged (`req_user`=1), or when bit 30 is set and the request is privileged. Otherwise the key is 0.
- R2: An instruction fetch whose segment has bit 28 (no-execute) set ends with status 3 and issues no memory read.
- R3: A segment with bit 31 set is a direct-store segment. Any access to it ends with status 4 and issues no memory read.
- R4: The hash is segment register bits 18:0 XOR the zero-extended page index `ea[27:12]`. Entry i of a group is read at `tbl_base + ((hash << 6) & tbl_mask) + 8*i`, with its first word at +0 and its second word at +4. The read address is held stable while `rd_ready` is low.
- R5: An entry matches only when three conditions hold: first-word bit 31 (valid) is set, first-word bit 6 equals the pass (0 for primary, 1 for secondary), and first-word bits 30:7 and 5:0 equal the 24-bit segment identifier (segment register bits 23:0) and page-index bits 15:10.
- R6: The secondary group, at the bitwise complement of the hash, is scanned only when the primary group gives no match or gives a match that fails the access check. If neither group matches, the status is 1 after exactly 16 first-word reads.
- R7: The rights come from second-word bits 1:0 (pp). With key 0, pp 0, 1 and 2 give read/write and pp 3 gives read only. With key 1, pp 0 gives nothing, pp 2 gives read/write, and pp 1 and pp 3 give read only. Execute is granted whenever the segment's no-execute bit is clear.
- R8: A load needs read, a store needs write and a fetch needs execute. If the last matching entry fails this check, the status is 2 and the changed bit (second-word bit 7) is not set.
- R9: On any match, the referenced bit (second-word bit 8) is set. The changed bit is set only for a store that passed the check. The updated second word is written back to its own address only when one of these bits went from 0 to 1.
- R10: The reported write permission is withheld unless the entry's changed bit is set after the access.
- R11: When a secondary match differs from an earlier primary match in second-word bits under the mask 0xFFFFF07B, the status is 5.
- R12: On a hit, the status is 0, `real_addr` is second-word bits 31:12 joined with `ea[11:0]`, and `done` is high for exactly one cycle.
- R13: Scanning of a group stops at the first matching entry, so entries after it are never read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_we | input | 1 | Segment register write enable |
| sr_sel | input | 4 | Segment register to write |
| sr_wdata | input | 32 | Segment register write value |
| tbl_base | input | 32 | Page table base byte address |
| tbl_mask | input | 32 | Mask applied to the group byte offset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is unprivileged |
| rd_valid | output | 1 | Table read request |
| rd_addr | output | 32 | Table read byte address |
| rd_ready | input | 1 | Read data present this cycle |
| rd_data | input | 32 | Table read word |
| wr_valid | output | 1 | Entry write-back request |
| wr_addr | output | 32 | Write-back byte address |
| wr_data | output | 32 | Updated second word |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 hit, 1 not found, 2 protection, 3 no-execute, 4 direct-store, 5 inconsistent |
| real_addr | output | 32 | Translated address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |

## Verification
The table of requests sends loads, stores and fetches from both privilege levels across four segment types. Together they separate key selection from the pp decode, and a primary hit from a secondary hit. They also separate a plain miss from a protection failure that was followed by a search of the secondary group. The groups are seeded with decoys placed before the real match: a valid entry with the wrong segment identifier, and one with the wrong hash-select bit. A duplicate placed after the match shows whether the scan stops at the first match. Repeating an access to the same entry tells a first touch, which writes back the referenced bit, from a first store, which writes back the changed bit, and both of these from a later access that writes nothing. Read and write counts per request, together with the final memory words, pin down how far each walk went.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

  // Result codes reported on the status port
  typedef enum logic [2:0] {
    ST_HIT    = 3'd0,
    ST_MISS   = 3'd1,
    ST_PROT   = 3'd2,
    ST_NOEXEC = 3'd3,
    ST_DIRECT = 3'd4,
    ST_INCONS = 3'd5
  } walk_status_e;

  // Segment register fields
  localparam int SR_T    = 31;
  localparam int SR_KS   = 30;
  localparam int SR_KP   = 29;
  localparam int SR_NX   = 28;
  localparam int VSID_W  = 24;
  localparam int API_W   = 6;
  localparam int PIDX_W  = 16;

  // Page-table entry fields
  localparam int PTE_V = 31;
  localparam int PTE_H = 6;
  localparam int PTE_R = 8;
  localparam int PTE_C = 7;
  localparam logic [31:0] CONSIST_MASK = 32'hFFFF_F07B;

  // Rights granted by pp under a key, returned as {read, write}
  function automatic logic [1:0] pp_rights(input logic key, input logic [1:0] pp);
    if (!key) return (pp == 2'b11) ? 2'b10 : 2'b11;
    case (pp)
      2'b00:   return 2'b00;
      2'b10:   return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/hpw_segfile.sv
module hpw_segfile #(
  parameter int NSEG  = 16,
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEG_W-1:0] wsel,
  input  logic [31:0]      wdata,
  input  logic [SEG_W-1:0] rsel,
  output logic [31:0]      rdata
);
  // Small register file, no reset, so it maps onto distributed RAM
  logic [31:0] regs [NSEG];

  always_ff @(posedge clk) begin
    if (we) regs[wsel] <= wdata;
  end

  assign rdata = regs[rsel];
endmodule

// File: rtl/hpw_segdecode.sv
module hpw_segdecode
  import hpw_pkg::*;
#(
  parameter int HASH_W = 19
) (
  input  logic [VSID_W-1:0]       vsid,
  input  logic                    ks,
  input  logic                    kp,
  input  logic [PIDX_W-1:0]       pidx,
  input  logic                    user,
  output logic                    key,
  output logic [VSID_W+API_W-1:0] tag,
  output logic [HASH_W-1:0]       hash
);
  assign key  = (kp & user) | (ks & ~user);
  assign tag  = {vsid, pidx[PIDX_W-1 -: API_W]};
  assign hash = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
endmodule

// File: rtl/hpw_pte_eval.sv
module hpw_pte_eval
  import hpw_pkg::*;
(
  input  logic [31:0] pte1,
  input  logic        key,
  input  logic        nx,
  input  logic        store,
  input  logic        fetch,
  output logic        ok,
  output logic        pr,
  output logic        pw,
  output logic        px,
  output logic [31:0] new_pte1,
  output logic        need_wb
);
  logic [1:0] rights;

  always_comb begin
    rights = pp_rights(key, pte1[1:0]);
    if (fetch)      ok = ~nx;
    else if (store) ok = rights[0];
    else            ok = rights[1];
    new_pte1        = pte1;
    new_pte1[PTE_R] = 1'b1;
    if (store && ok) new_pte1[PTE_C] = 1'b1;
    need_wb = (new_pte1 != pte1);
    pr = rights[1];
    pw = rights[0] & new_pte1[PTE_C];
    px = ~nx;
  end
endmodule

// File: rtl/hashed_pt_walker.sv
module hashed_pt_walker
  import hpw_pkg::*;
#(
  parameter int NSEG          = 16,
  parameter int GROUP_ENTRIES = 8,
  parameter int HASH_W        = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sr_we,
  input  logic [$clog2(NSEG)-1:0]  sr_sel,
  input  logic [31:0]              sr_wdata,
  input  logic [31:0]              tbl_base,
  input  logic [31:0]              tbl_mask,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [31:0]              req_ea,
  input  logic                     req_store,
  input  logic                     req_fetch,
  input  logic                     req_user,
  output logic                     rd_valid,
  output logic [31:0]              rd_addr,
  input  logic                     rd_ready,
  input  logic [31:0]              rd_data,
  output logic                     wr_valid,
  output logic [31:0]              wr_addr,
  output logic [31:0]              wr_data,
  input  logic                     wr_ready,
  output logic                     done,
  output logic [2:0]               status,
  output logic [31:0]              real_addr,
  output logic                     perm_r,
  output logic                     perm_w,
  output logic                     perm_x
);
  localparam int SEG_W     = $clog2(NSEG);
  localparam int IDX_W     = $clog2(GROUP_ENTRIES);
  localparam int ENT_SHIFT = 3;
  localparam int GRP_SHIFT = IDX_W + ENT_SHIFT;
  localparam int TAG_W     = VSID_W + API_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SEG, S_RD0, S_RD1, S_EVAL, S_WB} fsm_e;

  fsm_e            state;
  walk_status_e    status_q;
  logic [31:0]     ea_q, pte1_q, prev_pte1_q;
  logic            store_q, fetch_q, user_q, key_q, nx_q, pass_q, have_prev_q;
  logic [TAG_W-1:0]  tag_q;
  logic [HASH_W-1:0] hash_q;
  logic [IDX_W-1:0]  idx_q;

  // Segment lookup
  logic [31:0]       sr_rd;
  logic              seg_key;
  logic [TAG_W-1:0]  seg_tag;
  logic [HASH_W-1:0] seg_hash;
  logic              unused_sr_bits;

  hpw_segfile #(.NSEG(NSEG), .SEG_W(SEG_W)) u_segfile (
    .clk(clk), .we(sr_we), .wsel(sr_sel), .wdata(sr_wdata),
    .rsel(ea_q[31 -: SEG_W]), .rdata(sr_rd)
  );

  assign unused_sr_bits = ^sr_rd[27:VSID_W];

  hpw_segdecode #(.HASH_W(HASH_W)) u_segdecode (
    .vsid(sr_rd[VSID_W-1:0]), .ks(sr_rd[SR_KS]), .kp(sr_rd[SR_KP]),
    .pidx(ea_q[27:12]), .user(user_q),
    .key(seg_key), .tag(seg_tag), .hash(seg_hash)
  );

  // Entry evaluation
  logic        ev_ok, ev_pr, ev_pw, ev_px, ev_need_wb;
  logic [31:0] ev_new_pte1;

  hpw_pte_eval u_eval (
    .pte1(pte1_q), .key(key_q), .nx(nx_q), .store(store_q), .fetch(fetch_q),
    .ok(ev_ok), .pr(ev_pr), .pw(ev_pw), .px(ev_px),
    .new_pte1(ev_new_pte1), .need_wb(ev_need_wb)
  );

  // Address generation
  logic [HASH_W-1:0] hash_cur;
  logic [31:0]       grp_off, ent_addr;
  logic              pte0_match, incons, post_go;

  assign hash_cur = pass_q ? ~hash_q : hash_q;
  assign grp_off  = (32'(hash_cur) << GRP_SHIFT) & tbl_mask;
  assign ent_addr = tbl_base + grp_off + (32'(idx_q) << ENT_SHIFT);

  assign req_ready = (state == S_IDLE);
  assign rd_valid  = (state == S_RD0) || (state == S_RD1);
  assign rd_addr   = ent_addr + ((state == S_RD1) ? 32'd4 : 32'd0);
  assign wr_valid  = (state == S_WB);
  assign wr_addr   = ent_addr + 32'd4;
  assign wr_data   = ev_new_pte1;
  assign status    = status_q;

  assign pte0_match = rd_data[PTE_V] && (rd_data[PTE_H] == pass_q) &&
                      ({rd_data[30:7], rd_data[5:0]} == tag_q);
  assign incons  = have_prev_q && (((pte1_q ^ prev_pte1_q) & CONSIST_MASK) != 32'd0);
  assign post_go = ((state == S_EVAL) && !incons && !ev_need_wb) ||
                   ((state == S_WB) && wr_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      status_q    <= ST_HIT;
      done        <= 1'b0;
      real_addr   <= '0;
      perm_r      <= 1'b0;
      perm_w      <= 1'b0;
      perm_x      <= 1'b0;
      ea_q        <= '0;
      store_q     <= 1'b0;
      fetch_q     <= 1'b0;
      user_q      <= 1'b0;
      key_q       <= 1'b0;
      nx_q        <= 1'b0;
      tag_q       <= '0;
      hash_q      <= '0;
      pass_q      <= 1'b0;
      idx_q       <= '0;
      have_prev_q <= 1'b0;
      pte1_q      <= '0;
      prev_pte1_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          store_q <= req_store;
          fetch_q <= req_fetch;
          user_q  <= req_user;
          state   <= S_SEG;
        end
        S_SEG: begin
          key_q       <= seg_key;
          nx_q        <= sr_rd[SR_NX];
          tag_q       <= seg_tag;
          hash_q      <= seg_hash;
          pass_q      <= 1'b0;
          idx_q       <= '0;
          have_prev_q <= 1'b0;
          if (sr_rd[SR_T]) begin
            status_q <= ST_DIRECT; done <= 1'b1; state <= S_IDLE;
            {perm_r, perm_w, perm_x} <= 3'b000;
          end else if (fetch_q && sr_rd[SR_NX]) begin
            status_q <= ST_NOEXEC; done <= 1'b1; state <= S_IDLE;
            {perm_r, perm_w, perm_x} <= 3'b000;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (rd_ready) begin
          if (pte0_match) begin
            state <= S_RD1;
          end else if (idx_q != LAST_IDX) begin
            idx_q <= idx_q + 1'b1;
          end else if (!pass_q) begin
            pass_q <= 1'b1;
            idx_q  <= '0;
          end else begin
            status_q <= have_prev_q ? ST_PROT : ST_MISS;
            done     <= 1'b1;
            state    <= S_IDLE;
            {perm_r, perm_w, perm_x} <= 3'b000;
          end
        end
        S_RD1: if (rd_ready) begin
          pte1_q <= rd_data;
          state  <= S_EVAL;
        end
        S_EVAL: begin
          if (incons) begin
            status_q <= ST_INCONS; done <= 1'b1; state <= S_IDLE;
            {perm_r, perm_w, perm_x} <= 3'b000;
          end else if (ev_need_wb) begin
            state <= S_WB;
          end
        end
        S_WB: ;
        default: state <= S_IDLE;
      endcase

      // Shared exit once an entry has been evaluated and written back
      if (post_go) begin
        if (ev_ok) begin
          status_q  <= ST_HIT;
          done      <= 1'b1;
          state     <= S_IDLE;
          real_addr <= {pte1_q[31:12], ea_q[11:0]};
          perm_r    <= ev_pr;
          perm_w    <= ev_pw;
          perm_x    <= ev_px;
        end else if (!pass_q) begin
          pass_q      <= 1'b1;
          idx_q       <= '0;
          have_prev_q <= 1'b1;
          prev_pte1_q <= pte1_q;
          state       <= S_RD0;
        end else begin
          status_q <= ST_PROT; done <= 1'b1; state <= S_IDLE;
          {perm_r, perm_w, perm_x} <= 3'b000;
        end
      end
    end
  end

  // Checker state: reads per walk and the address of the last read
  logic [7:0]  rd_cnt_chk;
  logic [31:0] last_rd_addr_chk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt_chk       <= '0;
      last_rd_addr_chk <= '0;
    end else begin
      if (state == S_IDLE && req_valid) rd_cnt_chk <= '0;
      else if (rd_valid && rd_ready)    rd_cnt_chk <= rd_cnt_chk + 8'd1;
      if (rd_valid && rd_ready) last_rd_addr_chk <= rd_addr;
    end
  end

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_wb_target_R9: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ((wr_addr == last_rd_addr_chk) && wr_data[PTE_R]));

  assert_noexec_noread_R2: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_NOEXEC) |-> (rd_cnt_chk == 8'd0 && fetch_q));

  assert_direct_noread_R3: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_DIRECT) |-> (rd_cnt_chk == 8'd0));

  assert_miss_reads_R6: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_MISS) |-> (rd_cnt_chk == 8'(2 * GROUP_ENTRIES)));

  assert_store_write_R10: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_HIT && store_q) |-> perm_w);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/tb_hashed_pt_walker.sv
`timescale 1ns/1ps
module tb_hashed_pt_walker;
  import hpw_pkg::*;

  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] MASK = 32'h0000_3FC0;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [31:0] ea;
    logic        st;
    logic        fe;
    logic        us;
    logic [2:0]  stat;
    logic [31:0] ra;
    logic [2:0]  perm;   // {r, w, x}
    logic [4:0]  nrd;
    logic [1:0]  nwr;
  } vec_t;

  // Requests in order; table state carries over from one to the next
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_5ABC, 1'b0, 1'b0, 1'b1, 3'd0, 32'hABCD_EABC, 3'b101, 5'd4,  2'd1}, // R1 R5 R7 R9 R10 R12 R13
    '{32'h0000_5ABC, 1'b1, 1'b0, 1'b1, 3'd0, 32'hABCD_EABC, 3'b111, 5'd4,  2'd1}, // R9 R10
    '{32'h0000_5ABC, 1'b0, 1'b0, 1'b1, 3'd0, 32'hABCD_EABC, 3'b111, 5'd4,  2'd0}, // R9
    '{32'h0000_6010, 1'b1, 1'b0, 1'b1, 3'd2, 32'h0,         3'b000, 5'd10, 2'd1}, // R1 R6 R8
    '{32'h0000_6010, 1'b1, 1'b0, 1'b0, 3'd0, 32'h1111_1010, 3'b111, 5'd2,  2'd1}, // R1 R7
    '{32'h3000_2345, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_7345, 3'b111, 5'd15, 2'd0}, // R4 R6
    '{32'h3000_2345, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_7345, 3'b111, 5'd15, 2'd0}, // R8
    '{32'h3000_9000, 1'b0, 1'b0, 1'b0, 3'd1, 32'h0,         3'b000, 5'd16, 2'd0}, // R6
    '{32'h1000_0000, 1'b0, 1'b1, 1'b0, 3'd3, 32'h0,         3'b000, 5'd0,  2'd0}, // R2
    '{32'h2000_0000, 1'b0, 1'b0, 1'b0, 3'd4, 32'h0,         3'b000, 5'd0,  2'd0}, // R3
    '{32'h0000_7000, 1'b1, 1'b0, 1'b1, 3'd5, 32'h0,         3'b000, 5'd7,  2'd1}, // R11
    '{32'h3000_4000, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_5000, 3'b101, 5'd2,  2'd0}, // R7
    '{32'h3000_4000, 1'b1, 1'b0, 1'b0, 3'd2, 32'h0,         3'b000, 5'd10, 2'd0}, // R8
    '{32'h1000_1000, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_9000, 3'b110, 5'd2,  2'd0}  // R7 R12
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1/R5/R10/R12/R13";
      1: return "R9/R10";
      2: return "R9";
      3: return "R1/R6/R8";
      4: return "R1/R7";
      5: return "R4/R6";
      6: return "R8";
      7: return "R6";
      8: return "R2";
      9: return "R3";
      10: return "R11";
      11: return "R7";
      12: return "R8";
      default: return "R7/R12";
    endcase
  endfunction

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, sr_we, req_valid, req_ready, req_store, req_fetch, req_user;
  logic [3:0]  sr_sel;
  logic [31:0] sr_wdata, req_ea, rd_addr, rd_data, wr_addr, wr_data, real_addr;
  logic        rd_valid, rd_ready, wr_valid, wr_ready, done, perm_r, perm_w, perm_x;
  logic [2:0]  status;

  hashed_pt_walker dut (
    .clk(clk), .rst(rst), .sr_we(sr_we), .sr_sel(sr_sel), .sr_wdata(sr_wdata),
    .tbl_base(BASE), .tbl_mask(MASK),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_store(req_store), .req_fetch(req_fetch), .req_user(req_user),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .done(done), .status(status), .real_addr(real_addr),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  // Memory model with alternating stalls
  logic [31:0] mem [4096];
  logic        stall = 1'b0;
  int          nrd_tot = 0;
  int          nwr_tot = 0;

  function automatic int widx(logic [31:0] a);
    return int'(((a - BASE) >> 2) & 32'h0000_0FFF);
  endfunction

  always @(posedge clk) stall <= ~stall;
  assign rd_ready = rd_valid & ~stall;
  assign wr_ready = wr_valid & stall;
  assign rd_data  = mem[widx(rd_addr)];

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      mem[widx(wr_addr)] <= wr_data;
      nwr_tot <= nwr_tot + 1;
    end
    if (rd_valid && rd_ready) nrd_tot <= nrd_tot + 1;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(int off, int slot, logic [31:0] w0, logic [31:0] w1);
    mem[off / 4 + slot * 2]     = w0;
    mem[off / 4 + slot * 2 + 1] = w1;
  endtask

  task automatic sr_write(int i, logic [31:0] v);
    @(negedge clk);
    sr_we = 1'b1; sr_sel = 4'(i); sr_wdata = v;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual hang expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; sr_we = 1'b0; sr_sel = '0; sr_wdata = '0;
    req_valid = 1'b0; req_ea = '0; req_store = 1'b0; req_fetch = 1'b0; req_user = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // Group for ea 0x5ABC: decoys before the match, a duplicate after it
    put(32'h980, 0, 32'h8000_9200, 32'hDEAD_0002);
    put(32'h980, 1, 32'h8000_91C0, 32'hBEEF_0002);
    put(32'h980, 2, 32'h8000_9180, 32'hABCD_E002);
    put(32'h980, 3, 32'h8000_9180, 32'h5555_5002);
    put(32'h940, 0, 32'h8000_9180, 32'h1111_1000);
    put(32'h1D00, 5, 32'h8003_C4C0, 32'h0000_7181);
    put(32'h900, 0, 32'h8000_9180, 32'h2222_2000);
    put(32'h36C0, 3, 32'h8000_91C0, 32'h3333_3002);
    put(32'h2340, 0, 32'h8003_C480, 32'h0000_5183);
    put(32'h15C0, 0, 32'h8002_2B00, 32'h0000_9182);

    repeat (3) @(negedge clk);
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R12", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R4", "reset rd_valid", 32'(rd_valid), 32'd0);
    chk("R9", "reset wr_valid", 32'(wr_valid), 32'd0);
    rst = 1'b0;

    sr_write(0, 32'h2000_0123); // user key set
    sr_write(1, 32'h1000_0456); // no-execute
    sr_write(2, 32'h8000_0000); // direct-store
    sr_write(3, 32'h0000_0789); // both keys clear

    for (int v = 0; v < NVEC; v++) begin
      int rd0, wr0, c;
      @(negedge clk);
      rd0 = nrd_tot; wr0 = nwr_tot;
      req_valid = 1'b1; req_ea = VECS[v].ea;
      req_store = VECS[v].st; req_fetch = VECS[v].fe; req_user = VECS[v].us;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      c = 0;
      while (!done && c < 500) begin
        @(negedge clk);
        c++;
      end
      chk(vtag(v), "completion", 32'(done), 32'd1);
      chk(vtag(v), "status", 32'(status), 32'(VECS[v].stat));
      chk(vtag(v), "reads", 32'(nrd_tot - rd0), 32'(VECS[v].nrd));
      chk(vtag(v), "writes", 32'(nwr_tot - wr0), 32'(VECS[v].nwr));
      if (VECS[v].stat == 3'd0) begin
        chk(vtag(v), "real_addr", real_addr, VECS[v].ra);
        chk(vtag(v), "perms", 32'({perm_r, perm_w, perm_x}), 32'(VECS[v].perm));
      end
      @(negedge clk);
      chk("R12", "done pulse width", 32'(done), 32'd0);
    end

    // Written-back words and untouched entries
    chk("R9", "first-hit entry after store", mem[32'h980 / 4 + 5], 32'hABCD_E182);
    chk("R13", "entry after first match", mem[32'h980 / 4 + 7], 32'h5555_5002);
    chk("R8", "entry after failed then allowed store", mem[32'h940 / 4 + 1], 32'h1111_1180);
    chk("R11", "primary entry of conflicting pair", mem[32'h900 / 4 + 1], 32'h2222_2100);
    chk("R11", "secondary entry of conflicting pair", mem[32'h36C0 / 4 + 7], 32'h3333_3002);
    chk("R8", "read-only entry after refused store", mem[32'h2340 / 4 + 1], 32'h0000_5183);

    summary();
    $finish;
  end
endmodule